// File: doc/BRIEF.md
# Baud Tick Generator with Speed and Oversampling Modes

This block turns the system clock into the two timing strobes a serial port needs. A programmable divider produces a base tick. An oversampling counter then raises a bit strobe once every 16 or 8 base ticks. In synchronous mode it raises the bit strobe on every base tick. A 16-bit control register holds two live bits. One halves the divider period. The other picks the oversampling ratio.

The halving bit acts only under one condition: the port is asynchronous and the clock-enable field is 00, meaning an internal clock with the clock pin used as an input. Under every other setting the divider runs at its normal rate, and the bit stays stored but has no effect. The ratio bit acts only in asynchronous mode. A register write, or any change to the mode bit or the clock-enable field, restarts both counters from zero. No shortened period follows a reconfiguration.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `base_tick` and `bit_strobe` are low.
- R2: A write with `wr_en` high stores `wr_data[7]` as the double-speed bit and `wr_data[0]` as the ratio bit. On the next cycle `reg_rdata` returns them at bit 7 and bit 0.
- R3: `reg_rdata` bits 15:8 and 6:1 always read 0, whatever value was written to them.
- R4: In normal mode, `base_tick` pulses once every `divisor`+1 clocks.
- R5: When `sync_mode`=0, `cke_sel`=00 and bit 7=1, `base_tick` pulses every max(1, floor((`divisor`+1)/2)) clocks.
- R6: When `sync_mode`=1 or `cke_sel`≠00, bit 7 has no effect and the R4 period applies.
- R7: When `sync_mode`=0, `bit_strobe` pulses every 16 base ticks if bit 0=0, and every 8 base ticks if bit 0=1.
- R8: When `sync_mode`=1, `bit_strobe` pulses on every base tick, whatever the value of bit 0.
- R9: A write, or a change of `sync_mode` or `cke_sel`, clears both outputs on the following cycle. After that clock edge, the first base tick appears after exactly one full period P, and the first bit strobe after P times the ratio.
- R10: `bit_strobe` is high only in a cycle where `base_tick` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | DIV_W | Divider setting N; the normal period is N+1 clocks |
| sync_mode | input | 1 | 0 = asynchronous, 1 = synchronous |
| cke_sel | input | 2 | Clock-enable field; 00 = internal clock, pin as input |
| wr_data | input | 16 | Register write data |
| wr_en | input | 1 | Register write strobe |
| base_tick | output | 1 | One-clock base tick |
| bit_strobe | output | 1 | One-clock bit-rate strobe |
| reg_rdata | output | 16 | Register readback |

## Verification
The assertions assume that `divisor` changes only together with a restart. The bench follows this rule: it moves `divisor`, `sync_mode` and `cke_sel` only before the register write that starts each measurement. The bench then holds all inputs steady while it counts the edges to the first tick and to the first two bit strobes. It sweeps every combination of mode, clock-enable field, both register bits and a range of small divisors. One further case changes only `cke_sel` in the middle of a period, to show that a mode change alone restarts the counters.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             sync_mode,
  input  logic [1:0]       cke_sel,
  input  logic [15:0]      wr_data,
  input  logic             wr_en,
  output logic             base_tick,
  output logic             bit_strobe,
  output logic [15:0]      reg_rdata
);
  localparam int CW   = DIV_W + 1;
  localparam int OS_W = 4;

  logic            dbl_q, os8_q;
  logic [2:0]      cfg_q;
  logic [CW-1:0]   div_cnt;
  logic [OS_W-1:0] os_cnt;

  wire             dbl_eff = dbl_q & ~sync_mode & (cke_sel == 2'b00);
  wire [CW-1:0]    full    = CW'(divisor) + CW'(1);
  wire [CW-1:0]    half    = full >> 1;
  wire [CW-1:0]    period  = dbl_eff ? ((half == '0) ? CW'(1) : half) : full;
  wire [OS_W-1:0]  os_last = sync_mode ? OS_W'(0) : (os8_q ? OS_W'(7) : OS_W'(15));
  wire             restart = wr_en | ({sync_mode, cke_sel} != cfg_q);
  wire             div_wrap = div_cnt >= (period - CW'(1));
  wire             os_wrap  = os_cnt >= os_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbl_q      <= 1'b0;
      os8_q      <= 1'b0;
      cfg_q      <= 3'b000;
      div_cnt    <= '0;
      os_cnt     <= '0;
      base_tick  <= 1'b0;
      bit_strobe <= 1'b0;
    end else begin
      cfg_q <= {sync_mode, cke_sel};
      if (wr_en) begin
        dbl_q <= wr_data[7];
        os8_q <= wr_data[0];
      end
      if (restart) begin
        div_cnt    <= '0;
        os_cnt     <= '0;
        base_tick  <= 1'b0;
        bit_strobe <= 1'b0;
      end else if (div_wrap) begin
        div_cnt    <= '0;
        base_tick  <= 1'b1;
        bit_strobe <= os_wrap;
        os_cnt     <= os_wrap ? '0 : os_cnt + OS_W'(1);
      end else begin
        div_cnt    <= div_cnt + CW'(1);
        base_tick  <= 1'b0;
        bit_strobe <= 1'b0;
      end
    end
  end

  assign reg_rdata = {8'h00, dbl_q, 6'b000000, os8_q};

  p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (reg_rdata[7] == $past(wr_data[7])) && (reg_rdata[0] == $past(wr_data[0])));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (reg_rdata[15:8] == 8'h00) && (reg_rdata[6:1] == 6'h00));

  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || ({sync_mode, cke_sel} != cfg_q)) |=> !base_tick && !bit_strobe);

  p_sync_every_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !wr_en && ({sync_mode, cke_sel} == cfg_q) && div_wrap) |=> bit_strobe);

  p_strobe_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> base_tick);
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  divisor = 8'd0;
  logic        sync_mode = 1'b0;
  logic [1:0]  cke_sel = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic        wr_en = 1'b0;
  logic        base_tick, bit_strobe;
  logic [15:0] reg_rdata;
  int checks = 0;
  int errors = 0;

  baud_tick_gen #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .sync_mode(sync_mode),
    .cke_sel(cke_sel), .wr_data(wr_data), .wr_en(wr_en),
    .base_tick(base_tick), .bit_strobe(bit_strobe), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(input int n, input bit s, input int c, input bit w7, input bit w0);
    int full, p, os, t1, s1, s2, nt, lim;
    string rp, ro;
    full = n + 1;
    if (w7 && !s && c == 0) begin
      p = (full / 2 == 0) ? 1 : full / 2;
      rp = "R5";
    end else begin
      p = full;
      rp = (w7 ? "R6" : "R4");
    end
    os = s ? 1 : (w0 ? 8 : 16);
    ro = s ? "R8" : "R7";
    @(negedge clk);
    divisor = 8'(n); sync_mode = s; cke_sel = 2'(c);
    @(negedge clk);
    wr_data = 16'hFFFF; wr_data[7] = w7; wr_data[0] = w0; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 bit7", int'(reg_rdata[7]), int'(w7));
    check("R2 bit0", int'(reg_rdata[0]), int'(w0));
    check("R3 reserved", int'({reg_rdata[15:8], reg_rdata[6:1]}), 0);
    check("R9 cleared", int'(base_tick) + int'(bit_strobe), 0);
    t1 = 0; s1 = 0; s2 = 0; nt = 0;
    lim = 2 * p * os + 2;
    for (int k = 1; k <= lim; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (bit_strobe && !base_tick) check("R10 strobe without tick", 1, 0);
      if (base_tick) begin
        if (s2 == 0) nt++;
        if (t1 == 0) t1 = k;
      end
      if (bit_strobe) begin
        if (s1 == 0) s1 = k;
        else if (s2 == 0) s2 = k;
      end
    end
    check({rp, " first tick"}, t1, p);
    check({"R9 ", ro, " first strobe"}, s1, p * os);
    check({ro, " second strobe"}, s2, 2 * p * os);
    check({ro, " ticks per two strobes"}, nt, 2 * os);
  endtask

  initial begin
    int divs[7] = '{0, 1, 2, 3, 4, 5, 7};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 rdata", int'(reg_rdata), 0);
    check("R1 outputs", int'(base_tick) + int'(bit_strobe), 0);
    foreach (divs[i])
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 4; c++)
          for (int w = 0; w < 4; w++)
            run_cfg(divs[i], bit'(s), c, bit'(w >> 1), bit'(w & 1));
    // R9: change only cke_sel in the middle of a period
    run_cfg(5, 1'b0, 0, 1'b0, 1'b1);
    @(negedge clk);
    cke_sel = 2'b01;
    @(posedge clk);
    @(negedge clk);
    check("R9 mode change clears", int'(base_tick), 0);
    begin
      int t = 0;
      for (int k = 1; k <= 10; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (base_tick && t == 0) t = k;
      end
      check("R9 restart after mode change", t, 6);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule